// File: doc/BRIEF.md
# Quad Protected Switch Controller

This block is the digital core of a four-channel protected high-side power-switch driver. It accepts one ON/OFF command per channel, a global enable, and a set of monitor comparators that are already digital: supply over-limit, supply under-limit, a die-temperature warning, a pair of die-temperature comparators that bound a shutdown band, and one "output above reference" comparator per channel. From these it drives the four gate-enable outputs, an active-low common error flag, and an open-drain thermal-shutdown line that other parts of the system may also pull low. All asynchronous monitor inputs pass through two-flop synchronisers before use.

With the enable low the controller sleeps: all gates stay off and diagnostics read idle. After the enable rises, the gates stay off for an arming interval and then follow their commands, unless the supply leaves its window or a thermal shutdown is in force. The shutdown is hysteretic: it sets when the upper temperature comparator fires and clears only when the lower one drops. Each channel reports a load error when its output level disagrees with its command. The common error flag falls only after the combined fault condition has persisted for a programmable number of cycles, and releases as soon as the faults clear.

Top module: `quad_switch_guard`

## Requirements
- R1: While `enable_i` is low (after synchronisation) every bit of `gate_o` is 0, `err_n_o` is 1, `tsd_pull_o` is 1, and `load_err_o`, `stat_warn_o`, `stat_shut_o`, `stat_ovp_o` are all 0.
- R2: After `enable_i` rises, `gate_o` stays all-zero for ARM_CYC cycles; afterwards bit i of `gate_o` equals `cmd_i[i]` when no blocking condition is present.
- R3: While `ovp_i` or `uvp_i` is high, every bit of `gate_o` is 0; when both return low the gates again follow `cmd_i`. `stat_ovp_o` is 1 while awake and `ovp_i` is high.
- R4: `tshut_set_i` high turns on a shutdown state that forces `gate_o` to 0 and drives `tsd_pull_o` to 1; the state persists while `tshut_hold_i` stays high after `tshut_set_i` falls, and ends only when `tshut_hold_i` goes low.
- R5: `temp_warn_i` high sets `stat_warn_o` and leaves `gate_o` unchanged.
- R6: Bit i of `load_err_o` is 1 while awake when `cmd_i[i]`=1 and `out_hi_i[i]`=0, or when `cmd_i[i]`=0 and `out_hi_i[i]`=1; otherwise 0.
- R7: `err_n_o` falls only after the OR of load errors, warning, shutdown status and over-voltage has been continuously high for ERR_DLY cycles; any gap restarts the count, and the flag returns to 1 within a few cycles of all faults clearing.
- R8: While awake, `tsd_line_i` low with `tsd_pull_o` at 0 forces `gate_o` to 0 and sets `stat_shut_o`, as a thermal shutdown does.
- R9: `uvp_i` alone turns the gates off but is not an error-flag source: with all commands off and `uvp_i` high, `err_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global enable; low puts the block to sleep |
| cmd_i | input | NCH | Per-channel ON/OFF command |
| ovp_i | input | 1 | Supply above the over-voltage threshold |
| uvp_i | input | 1 | Supply below the under-voltage threshold |
| temp_warn_i | input | 1 | Die above the warning temperature |
| tshut_set_i | input | 1 | Die above the shutdown-entry temperature |
| tshut_hold_i | input | 1 | Die above the shutdown-exit temperature |
| out_hi_i | input | NCH | Per-channel output above the load-check reference |
| tsd_line_i | input | 1 | Observed level of the shared thermal-shutdown line |
| tsd_pull_o | output | 1 | 1 pulls the shared thermal-shutdown line low |
| gate_o | output | NCH | Per-channel gate enable |
| err_n_o | output | 1 | Active-low common error flag |
| load_err_o | output | NCH | Per-channel load error |
| stat_warn_o | output | 1 | Temperature warning status |
| stat_shut_o | output | 1 | Thermal shutdown status (internal or external) |
| stat_ovp_o | output | 1 | Over-voltage status |

## Verification
The bench builds the controller with ARM_CYC of 20 and ERR_DLY of 12 instead of the tens of thousands of cycles a real clock needs, so both the arming window and the flag masking window can be straddled, with checks just inside and just past each edge. The short masking delay also lets a pulse train whose pulses are each shorter than the delay be shown never to drop the flag. The thermal hysteresis band, the externally pulled shutdown line and the supply window are each driven through set, hold and release.

// File: rtl/qsg_pkg.sv
package qsg_pkg;
  typedef struct packed {
    logic warn;
    logic shut;
    logic ovp;
  } qsg_stat_t;
endpackage

// File: rtl/qsg_sync.sv
module qsg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/qsg_supervisor.sv
module qsg_supervisor #(
  parameter int NCH     = 4,
  parameter int ARM_CYC = 7500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_s,
  input  logic [NCH-1:0] cmd,
  input  logic           ovp_s,
  input  logic           uvp_s,
  input  logic           set_s,
  input  logic           hold_s,
  input  logic           line_s,
  output logic [NCH-1:0] gate_o,
  output logic           hot_o
);
  localparam int AW = $clog2(ARM_CYC + 1);
  localparam logic [AW-1:0] ARM_END = AW'(ARM_CYC);

  logic [AW-1:0]  arm_cnt_q, arm_cnt_d;
  logic           hot_q, hot_d;
  logic [NCH-1:0] gate_q, gate_d;
  logic           armed;
  logic           block;

  always_comb begin
    armed = en_s && (arm_cnt_q == ARM_END);
    if (!en_s)             arm_cnt_d = '0;
    else if (!armed)       arm_cnt_d = arm_cnt_q + 1'b1;
    else                   arm_cnt_d = arm_cnt_q;

    if (!en_s)             hot_d = 1'b0;
    else if (set_s)        hot_d = 1'b1;
    else if (!hold_s)      hot_d = 1'b0;
    else                   hot_d = hot_q;

    block  = ovp_s || uvp_s || hot_q || !line_s;
    gate_d = (armed && !block) ? cmd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt_q <= '0;
      hot_q     <= 1'b0;
      gate_q    <= '0;
    end else begin
      arm_cnt_q <= arm_cnt_d;
      hot_q     <= hot_d;
      gate_q    <= gate_d;
    end
  end

  assign gate_o = gate_q;
  assign hot_o  = hot_q;

  // R1
  sleep_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (gate_q == '0));
  // R2
  arm_before_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != '0) |-> $past(armed));
  // R3
  supply_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_s || uvp_s) |=> (gate_q == '0));
  // R4
  hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && hot_q && hold_s) |=> hot_q);
  // R4
  hot_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_q |=> (gate_q == '0));
endmodule

// File: rtl/qsg_load_check.sv
module qsg_load_check #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_s,
  input  logic [NCH-1:0] cmd,
  input  logic [NCH-1:0] out_s,
  output logic [NCH-1:0] err_o
);
  logic [NCH-1:0] err_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic err_d;
    always_comb begin
      if (!en_s)       err_d = 1'b0;
      else if (cmd[i]) err_d = !out_s[i];
      else             err_d = out_s[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[i] <= 1'b0;
      else        err_q[i] <= err_d;
    end
  end

  assign err_o = err_q;

  // R6
  load_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (err_q == '0));
endmodule

// File: rtl/qsg_err_delay.sv
module qsg_err_delay #(
  parameter int ERR_DLY = 18750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic err_n_o
);
  localparam int CW = $clog2(ERR_DLY + 1);
  localparam logic [CW-1:0] DLY_END = CW'(ERR_DLY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_n_q, err_n_d;

  always_comb begin
    if (!fault)                cnt_d = '0;
    else if (cnt_q != DLY_END) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
    err_n_d = !(fault && (cnt_d == DLY_END));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      err_n_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      err_n_q <= err_n_d;
    end
  end

  assign err_n_o = err_n_q;

  // R7
  flag_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> err_n_q);
  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n_q) |-> $past(fault));
endmodule

// File: rtl/quad_switch_guard.sv
module quad_switch_guard
  import qsg_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int ARM_CYC = 7500,
  parameter int ERR_DLY = 18750
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable_i,
  input  logic [NCH-1:0] cmd_i,
  input  logic           ovp_i,
  input  logic           uvp_i,
  input  logic           temp_warn_i,
  input  logic           tshut_set_i,
  input  logic           tshut_hold_i,
  input  logic [NCH-1:0] out_hi_i,
  input  logic           tsd_line_i,
  output logic           tsd_pull_o,
  output logic [NCH-1:0] gate_o,
  output logic           err_n_o,
  output logic [NCH-1:0] load_err_o,
  output logic           stat_warn_o,
  output logic           stat_shut_o,
  output logic           stat_ovp_o
);
  localparam int SW = NCH + 7;

  logic [SW-1:0]  raw, synced;
  logic           en_s, ovp_s, uvp_s, warn_s, set_s, hold_s, line_s;
  logic [NCH-1:0] out_s;
  logic [NCH-1:0] gate;
  logic           hot;
  logic [NCH-1:0] load_err;
  qsg_stat_t      stat;
  logic           fault_any;

  assign raw = {out_hi_i, tsd_line_i, tshut_hold_i, tshut_set_i,
                temp_warn_i, uvp_i, ovp_i, enable_i};

  qsg_sync #(.W(SW)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw),
    .q_o  (synced)
  );

  assign {out_s, line_s, hold_s, set_s, warn_s, uvp_s, ovp_s, en_s} = synced;

  qsg_supervisor #(.NCH(NCH), .ARM_CYC(ARM_CYC)) i_sup (
    .clk   (clk),
    .rst_n (rst_n),
    .en_s  (en_s),
    .cmd   (cmd_i),
    .ovp_s (ovp_s),
    .uvp_s (uvp_s),
    .set_s (set_s),
    .hold_s(hold_s),
    .line_s(line_s),
    .gate_o(gate),
    .hot_o (hot)
  );

  qsg_load_check #(.NCH(NCH)) i_load (
    .clk  (clk),
    .rst_n(rst_n),
    .en_s (en_s),
    .cmd  (cmd_i),
    .out_s(out_s),
    .err_o(load_err)
  );

  always_comb begin
    stat.warn = en_s && warn_s;
    stat.shut = en_s && (hot || !line_s);
    stat.ovp  = en_s && ovp_s;
    fault_any = (|load_err) || stat.warn || stat.shut || stat.ovp;
  end

  qsg_err_delay #(.ERR_DLY(ERR_DLY)) i_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .fault  (fault_any),
    .err_n_o(err_n_o)
  );

  assign tsd_pull_o  = !en_s || hot;
  assign gate_o      = gate;
  assign load_err_o  = load_err;
  assign stat_warn_o = stat.warn;
  assign stat_shut_o = stat.shut;
  assign stat_ovp_o  = stat.ovp;

  // R8
  ext_line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && !line_s) |=> (gate == '0));
  // R1
  sleep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && $past(!en_s)) |-> (err_n_o && tsd_pull_o));
endmodule

// File: tb/test_quad_switch_guard.sv
module test_quad_switch_guard;
  localparam int NCH = 4;
  localparam int ARM = 20;
  localparam int DLY = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           enable_i, ovp_i, uvp_i, temp_warn_i, tshut_set_i, tshut_hold_i;
  logic [NCH-1:0] cmd_i;
  logic           ext_pull, ovr_en;
  logic [NCH-1:0] ovr_val;
  logic [NCH-1:0] out_hi;
  logic           tsd_line, tsd_pull_o, err_n_o;
  logic           stat_warn_o, stat_shut_o, stat_ovp_o;
  logic [NCH-1:0] gate_o, load_err_o;
  int             n_chk = 0;
  int             n_err = 0;
  bit             done = 0;

  always #2 clk = ~clk;

  assign out_hi   = ovr_en ? ovr_val : gate_o;
  assign tsd_line = ~(tsd_pull_o | ext_pull);

  quad_switch_guard #(.NCH(NCH), .ARM_CYC(ARM), .ERR_DLY(DLY)) i_quad_switch_guard (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .cmd_i(cmd_i),
    .ovp_i(ovp_i), .uvp_i(uvp_i), .temp_warn_i(temp_warn_i),
    .tshut_set_i(tshut_set_i), .tshut_hold_i(tshut_hold_i),
    .out_hi_i(out_hi), .tsd_line_i(tsd_line), .tsd_pull_o(tsd_pull_o),
    .gate_o(gate_o), .err_n_o(err_n_o), .load_err_o(load_err_o),
    .stat_warn_o(stat_warn_o), .stat_shut_o(stat_shut_o), .stat_ovp_o(stat_ovp_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_sleep(input string tag);
    wait_cyc(6);
    check({tag, " gates off"}, gate_o, 0);
    check({tag, " flag released"}, err_n_o, 1);
    check({tag, " line pulled"}, tsd_pull_o, 1);
    check({tag, " diag idle"}, {load_err_o, stat_warn_o, stat_shut_o, stat_ovp_o}, 0);
  endtask

  task automatic t_arm();
    cmd_i = 4'b1011;
    enable_i = 1'b1;
    wait_cyc(15);
    check("R2 gates held during arming", gate_o, 0);
    wait_cyc(15);
    check("R2 gates follow command", gate_o, 4'b1011);
    check("R8 line released when awake", {tsd_pull_o, stat_shut_o}, 0);
    wait_cyc(40);
  endtask

  task automatic t_supply();
    ovp_i = 1'b1;
    wait_cyc(6);
    check("R3 overvoltage gates off", gate_o, 0);
    check("R3 overvoltage status", stat_ovp_o, 1);
    ovp_i = 1'b0;
    wait_cyc(8);
    check("R3 recover after overvoltage", gate_o, 4'b1011);
    uvp_i = 1'b1;
    wait_cyc(6);
    check("R3 undervoltage gates off", gate_o, 0);
    check("R3 undervoltage no ovp status", stat_ovp_o, 0);
    uvp_i = 1'b0;
    wait_cyc(8);
    check("R3 recover after undervoltage", gate_o, 4'b1011);
    wait_cyc(40);
  endtask

  task automatic t_thermal();
    tshut_hold_i = 1'b1;
    wait_cyc(6);
    check("R4 hold alone does not shut", gate_o, 4'b1011);
    tshut_set_i = 1'b1;
    wait_cyc(6);
    check("R4 shutdown gates off", gate_o, 0);
    check("R4 shutdown pulls line and status", {tsd_pull_o, stat_shut_o}, 2'b11);
    tshut_set_i = 1'b0;
    wait_cyc(10);
    check("R4 hysteresis keeps shutdown", gate_o, 0);
    check("R4 hysteresis keeps line pulled", tsd_pull_o, 1);
    tshut_hold_i = 1'b0;
    wait_cyc(10);
    check("R4 shutdown exit gates resume", gate_o, 4'b1011);
    check("R4 shutdown exit status", {tsd_pull_o, stat_shut_o}, 0);
    wait_cyc(40);
  endtask

  task automatic t_warn();
    check("R7 flag idle before warning", err_n_o, 1);
    temp_warn_i = 1'b1;
    wait_cyc(6);
    check("R5 warning leaves gates", gate_o, 4'b1011);
    check("R5 warning status", stat_warn_o, 1);
    wait_cyc(20);
    check("R7 warning drops flag after delay", err_n_o, 0);
    check("R5 gates still on under warning", gate_o, 4'b1011);
    temp_warn_i = 1'b0;
    wait_cyc(5);
    check("R7 flag releases after warning clears", err_n_o, 1);
    wait_cyc(10);
  endtask

  task automatic t_load();
    cmd_i = 4'b0101;
    ovr_en = 1'b1;
    ovr_val = 4'b0110;
    wait_cyc(6);
    check("R6 load classification mixed", load_err_o, 4'b0011);
    ovr_val = 4'b0101;
    wait_cyc(6);
    check("R6 matching levels no error", load_err_o, 4'b0000);
    ovr_val = 4'b1010;
    wait_cyc(6);
    check("R6 all disagree", load_err_o, 4'b1111);
    ovr_en = 1'b0;
    wait_cyc(40);
  endtask

  task automatic t_err_delay();
    int lows;
    cmd_i = 4'b0000;
    wait_cyc(30);
    check("R7 flag idle before overvoltage", err_n_o, 1);
    ovp_i = 1'b1;
    wait_cyc(10);
    check("R7 flag masked inside delay", err_n_o, 1);
    wait_cyc(12);
    check("R7 flag low after delay", err_n_o, 0);
    ovp_i = 1'b0;
    wait_cyc(5);
    check("R7 flag quick release", err_n_o, 1);
    lows = 0;
    for (int p = 0; p < 3; p++) begin
      ovp_i = 1'b1;
      for (int k = 0; k < 8; k++) begin @(negedge clk); if (!err_n_o) lows++; end
      ovp_i = 1'b0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (!err_n_o) lows++; end
    end
    wait_cyc(6);
    check("R7 gaps restart the delay", lows, 0);
    uvp_i = 1'b1;
    wait_cyc(30);
    check("R9 undervoltage not a flag source", err_n_o, 1);
    check("R9 undervoltage gates off", gate_o, 0);
    uvp_i = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_ext_line();
    cmd_i = 4'b1111;
    wait_cyc(40);
    check("R8 gates on before external pull", gate_o, 4'b1111);
    ext_pull = 1'b1;
    wait_cyc(6);
    check("R8 external pull gates off", gate_o, 0);
    check("R8 external pull status, no own pull", {stat_shut_o, tsd_pull_o}, 2'b10);
    ext_pull = 1'b0;
    wait_cyc(8);
    check("R8 release resumes gates", gate_o, 4'b1111);
  endtask

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; enable_i = 1'b0; cmd_i = '0; ovp_i = 1'b0; uvp_i = 1'b0;
    temp_warn_i = 1'b0; tshut_set_i = 1'b0; tshut_hold_i = 1'b0;
    ext_pull = 1'b0; ovr_en = 1'b0; ovr_val = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    t_sleep("R1 after reset");
    t_arm();
    t_supply();
    t_thermal();
    t_warn();
    t_load();
    t_err_delay();
    t_ext_line();
    enable_i = 1'b0;
    t_sleep("R1 back to sleep");
    finish_sim();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      finish_sim();
    end
  end
endmodule